// File: doc/BRIEF.md
# Line Clamp Window Generator

This block produces a once-per-line clamp window for the analog front end of a video digitiser. It counts pixel-clock periods from the moment horizontal sync ends, waits a programmable number of periods so the input can settle on the back porch, then holds an active-high clamp window for a programmable number of periods. The start is taken from the end of sync rather than its start because sync width differs between video modes, while the black reference always follows sync.

A source select can replace the internal timer with an external clamp pin. A polarity bit converts that pin to active high. The block also turns one select bit per channel into that channel's clamp target code: midscale for colour-difference inputs, ground for the others. All configuration arrives on plain input ports and is expected to stay steady while a line is in progress. There is no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

The usual starting setting is a placement of 4 periods and a duration of 40 periods.

Top module: `clamp_window_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first end of sync, `clamp_win` is 0 (internal source selected).
- R2: Call E0 the first rising clock edge at which sync is sampled inactive after being sampled active. With the internal source, `clamp_win` rises after clock edge E0+1+P, where P is `clamp_place`.
- R3: The window stays high for exactly D clock periods, where D is `clamp_dur`, and falls after edge E0+1+P+D.
- R4: A duration of 0 produces no window on that line.
- R5: A new end of sync that arrives while a window is still pending restarts the placement count from the new edge.
- R6: With the internal source, `clamp_win` is 0 whenever sync is active. A window that would run into the next sync pulse is cut off when sync asserts and does not resume after that sync pulse ends.
- R7: When `hsync_act_hi` is 1, sync is active while `hsync_in` is 1. When `hsync_act_hi` is 0, sync is active while `hsync_in` is 0. Timing follows the trailing edge in either case.
- R8: When `clamp_src_ext` is 1, `clamp_win` equals `clamp_ext_in` when `clamp_ext_act_lo` is 0, and the inverse of `clamp_ext_in` when `clamp_ext_act_lo` is 1.
- R9: Field i of `clamp_tgt_code` (bits [10*i+9:10*i]) is 512 when `tgt_mid_sel[i]` is 1 and 0 when it is 0.
- R10: A placement of 0 starts the window after edge E0+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync as received |
| hsync_act_hi | input | 1 | 1: sync is active high; 0: sync is active low |
| clamp_ext_in | input | 1 | External clamp pin |
| clamp_src_ext | input | 1 | 1: use the external pin; 0: use the internal timer |
| clamp_ext_act_lo | input | 1 | 1: the external pin is active low |
| clamp_place | input | 8 | Pixel periods from the end of sync to the window start |
| clamp_dur | input | 8 | Window length in pixel periods |
| tgt_mid_sel | input | 3 | Per-channel midscale (1) or ground (0) target select |
| clamp_win | output | 1 | Active-high clamp window |
| clamp_tgt_code | output | 30 | Per-channel clamp target codes, 10 bits each |

## Verification
The bench builds the block with its default parameters: an 8-bit counter width, three channels and a 10-bit code width. With these values, the extreme settings (placement and duration of 255, and placement and duration of 0) can be reached in short runs. The three channels make it possible to drive every one of the eight target-select combinations. The reference model counts clock edges since the last end of sync and predicts the window on every cycle. It also covers sync-polarity changes, windows cut off by the next sync pulse, and switching to the external source in both polarities.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic [1:0] {
    CW_IDLE   = 2'd0,
    CW_PLACE  = 2'd1,
    CW_ACTIVE = 2'd2
  } cw_state_e;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  input  logic act_hi,
  output logic sync_now,
  output logic sync_q,
  output logic trail
);
  logic sync_qq;

  // normalise to active high
  assign sync_now = act_hi ? sync_raw : ~sync_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      sync_qq <= 1'b0;
    end else begin
      sync_q  <= sync_now;
      sync_qq <= sync_q;
    end
  end

  assign trail = sync_qq & ~sync_q;

  // the end-of-sync strobe lasts a single cycle
  p_trail_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> !trail);
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
  import clamp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trail,
  input  logic             sync_q,
  input  logic [CNT_W-1:0] place,
  input  logic [CNT_W-1:0] dur,
  output logic             win_raw
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cw_state_e        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CW_IDLE;
      cnt   <= '0;
    end else if (sync_q) begin
      state <= CW_IDLE;
      cnt   <= '0;
    end else if (trail) begin
      if (place != '0) begin
        state <= CW_PLACE;
        cnt   <= place;
      end else if (dur != '0) begin
        state <= CW_ACTIVE;
        cnt   <= dur;
      end else begin
        state <= CW_IDLE;
        cnt   <= '0;
      end
    end else begin
      unique case (state)
        CW_PLACE: begin
          if (cnt == ONE) begin
            if (dur != '0) begin
              state <= CW_ACTIVE;
              cnt   <= dur;
            end else begin
              state <= CW_IDLE;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt - ONE;
          end
        end
        CW_ACTIVE: begin
          if (cnt == ONE) begin
            state <= CW_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: begin
          state <= CW_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign win_raw = (state == CW_ACTIVE);

  // a registered sync assertion always clears the timer
  p_sync_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> (state == CW_IDLE));

  // the end of sync loads the placement (or goes straight to the window)
  p_trail_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> ((state == CW_PLACE) && (cnt == $past(place))) ||
              ((state == CW_ACTIVE) && ($past(place) == '0)) ||
              ((state == CW_IDLE) && ($past(place) == '0) && ($past(dur) == '0)));

  // an open window never holds a zero remaining count
  p_active_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CW_ACTIVE) |-> (cnt != '0));

  // the window shortens by one period per clock
  p_dur_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == CW_ACTIVE) && (cnt > ONE) && !sync_q && !trail) |=>
      ((state == CW_ACTIVE) && (cnt == $past(cnt) - ONE)));
endmodule

// File: rtl/clamp_tgt_map.sv
module clamp_tgt_map #(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 10
) (
  input  logic [NUM_CH-1:0]        mid_sel,
  output logic [NUM_CH*CODE_W-1:0] tgt_code
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign tgt_code[ch*CODE_W +: CODE_W] = mid_sel[ch] ? MID_CODE : '0;
  end
endmodule

// File: rtl/clamp_window_gen.sv
module clamp_window_gen #(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 3,
  parameter int CODE_W = 10
) (
  input  logic                     clk_pix,
  input  logic                     rst_n,
  input  logic                     hsync_in,
  input  logic                     hsync_act_hi,
  input  logic                     clamp_ext_in,
  input  logic                     clamp_src_ext,
  input  logic                     clamp_ext_act_lo,
  input  logic [CNT_W-1:0]         clamp_place,
  input  logic [CNT_W-1:0]         clamp_dur,
  input  logic [NUM_CH-1:0]        tgt_mid_sel,
  output logic                     clamp_win,
  output logic [NUM_CH*CODE_W-1:0] clamp_tgt_code
);
  logic sync_now, sync_q, trail, win_raw, ext_win;

  sync_edge_det u_edge (
    .clk      (clk_pix),
    .rst_n    (rst_n),
    .sync_raw (hsync_in),
    .act_hi   (hsync_act_hi),
    .sync_now (sync_now),
    .sync_q   (sync_q),
    .trail    (trail)
  );

  clamp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk_pix),
    .rst_n   (rst_n),
    .trail   (trail),
    .sync_q  (sync_q),
    .place   (clamp_place),
    .dur     (clamp_dur),
    .win_raw (win_raw)
  );

  clamp_tgt_map #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_tgt (
    .mid_sel  (tgt_mid_sel),
    .tgt_code (clamp_tgt_code)
  );

  assign ext_win   = clamp_ext_in ^ clamp_ext_act_lo;
  assign clamp_win = clamp_src_ext ? ext_win : (win_raw & ~sync_now);

  // internal window is silent during sync
  p_quiet_in_sync_r6: assert property (@(posedge clk_pix) disable iff (!rst_n)
    (!clamp_src_ext && sync_now) |-> !clamp_win);
endmodule

// File: tb/tb_clamp_window_gen.sv
module tb_clamp_window_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic       hsync_act_hi = 1'b1;
  logic       clamp_ext_in = 1'b0;
  logic       clamp_src_ext = 1'b0;
  logic       clamp_ext_act_lo = 1'b0;
  logic [7:0] clamp_place = 8'd4;
  logic [7:0] clamp_dur = 8'd40;
  logic [2:0] tgt_mid_sel = 3'b000;
  logic       clamp_win;
  logic [29:0] clamp_tgt_code;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    chk_en  = 1'b0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  // reference model state: edges since the last end of sync (-1 = none)
  int  since = -1;
  bit  prev_act = 1'b0;

  always #2.5 clk = ~clk;

  clamp_window_gen dut (
    .clk_pix          (clk),
    .rst_n            (rst_n),
    .hsync_in         (hsync_in),
    .hsync_act_hi     (hsync_act_hi),
    .clamp_ext_in     (clamp_ext_in),
    .clamp_src_ext    (clamp_src_ext),
    .clamp_ext_act_lo (clamp_ext_act_lo),
    .clamp_place      (clamp_place),
    .clamp_dur        (clamp_dur),
    .tgt_mid_sel      (tgt_mid_sel),
    .clamp_win        (clamp_win),
    .clamp_tgt_code   (clamp_tgt_code)
  );

  function automatic bit sync_act();
    return hsync_act_hi ? hsync_in : ~hsync_in;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      since    = -1;
      prev_act = 1'b0;
    end else begin
      bit sa;
      sa = sync_act();
      if (prev_act && !sa) since = 0;
      else if (sa) since = -1;
      else if (since >= 0) since = since + 1;
      prev_act = sa;
    end
  end

  function automatic bit model_win();
    int p, d;
    bit iw;
    p  = int'(clamp_place);
    d  = int'(clamp_dur);
    iw = (since >= 1 + p) && (since < 1 + p + d) && !sync_act();
    if (clamp_src_ext) return clamp_ext_in ^ clamp_ext_act_lo;
    return iw;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && rst_n) check(cur_req, 32'(clamp_win), 32'(model_win()));
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic line(int sw, int lw);
    hsync_in = hsync_act_hi;
    tick(sw);
    hsync_in = ~hsync_act_hi;
    tick(lw);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(3);
    #1 check("R1", 32'(clamp_win), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    tick(2);
    check("R1", 32'(clamp_win), 32'd0);
    chk_en = 1'b1;
    tick(5);

    // R2 / R3: recommended defaults
    cur_req = "R2_R3";
    clamp_place = 8'd4; clamp_dur = 8'd40;
    repeat (3) line(10, 100);
    clamp_place = 8'd7; clamp_dur = 8'd3;
    repeat (2) line(1, 30);

    // R10: zero placement
    cur_req = "R10";
    clamp_place = 8'd0; clamp_dur = 8'd1;
    repeat (2) line(3, 20);
    clamp_dur = 8'd5;
    line(2, 20);

    // R4: zero duration
    cur_req = "R4";
    clamp_place = 8'd2; clamp_dur = 8'd0;
    repeat (2) line(5, 30);
    clamp_place = 8'd0;
    line(5, 30);

    // R6: window cut by the next sync
    cur_req = "R6";
    clamp_place = 8'd20; clamp_dur = 8'd200;
    repeat (3) line(8, 60);
    clamp_place = 8'd255; clamp_dur = 8'd255;
    line(4, 600);

    // R5: sync returns during placement, count restarts
    cur_req = "R5";
    clamp_place = 8'd30; clamp_dur = 8'd5;
    repeat (4) line(2, 15);
    line(2, 60);

    // R7: active-low sync
    cur_req = "R7";
    hsync_act_hi = 1'b0; hsync_in = 1'b1;
    tick(5);
    clamp_place = 8'd4; clamp_dur = 8'd40;
    repeat (2) line(10, 80);
    clamp_place = 8'd1; clamp_dur = 8'd2;
    line(3, 20);

    // R8: external source, both polarities
    cur_req = "R8";
    clamp_src_ext = 1'b1;
    for (int pol = 0; pol < 2; pol++) begin
      clamp_ext_act_lo = pol[0];
      for (int k = 0; k < 6; k++) begin
        clamp_ext_in = k[0];
        hsync_in = (k % 3 == 0) ? ~hsync_act_hi : hsync_act_hi;
        tick(3);
      end
    end
    hsync_in = ~hsync_act_hi;
    clamp_ext_in = 1'b0;
    line(4, 30);
    clamp_src_ext = 1'b0;
    clamp_ext_act_lo = 1'b0;
    cur_req = "R2_R3";
    line(4, 60);

    // R9: target code mapping
    for (int s = 0; s < 8; s++) begin
      logic [29:0] exp_code;
      tgt_mid_sel = s[2:0];
      #1;
      for (int c = 0; c < 3; c++)
        exp_code[c*10 +: 10] = s[c] ? 10'd512 : 10'd0;
      check("R9", 32'(clamp_tgt_code), 32'(exp_code));
    end

    chk_en = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule